// File: doc/BRIEF.md
# Edge-Cause GPIO Controller

This block is a memory-mapped general-purpose I/O controller for up to 32 pins. The parameter `NPINS` sets how many are implemented; any pin at or above that index is absent. Software reaches the block through a simple single-cycle write bus and a combinational read path. There are four 32-bit windows, chosen by a 2-bit window select. The set and clear windows change the output-enable and output-data registers one bit at a time, so a caller never needs a read-modify-write to drive a pin.

The main window holds per-pin rising-edge and falling-edge enables and shows the synchronized input levels. Each input passes through a two-flop synchronizer. An edge is found by comparing the synchronized level with its value one clock earlier. A qualifying edge latches a per-pin cause bit. The cause window holds an event mask, returns the causes already gated by that mask, and clears causes with a write-one-to-clear port. A single level interrupt is high while any unmasked cause is pending, so it can be shared with other sources.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, output enables, output data, both edge-enable registers, all causes and the event mask are zero, and `irq` is low.
- R2: Set window (`winSel`=2): writing offset 0x00 sets every output-enable bit whose `wrData` bit is 1. Writing offset 0x04 does the same for output data. Bits written as 0 keep their value. Reading offset 0x00 or 0x04 in either the set or the clear window returns the current output-enable or output-data register.
- R3: Clear window (`winSel`=3): writing 1 to a bit at offset 0x00 clears that output-enable bit. Writing 1 to a bit at offset 0x04 clears that output-data bit. Bits written as 0 keep their value.
- R4: Main window (`winSel`=0): offset 0x00 is the read/write rising-edge enable and offset 0x04 is the read/write falling-edge enable. Offset 0x08 is read-only and returns the pin levels after the two-flop synchronizer.
- R5: A pin's cause latches on a 0-to-1 input transition when its rising enable is set, and on a 1-to-0 transition when its falling enable is set. With both enables set, either transition latches the cause. With neither set, the cause does not latch.
- R6: Cause window (`winSel`=1): offset 0x14 is the read/write event mask. Reading offset 0x00 returns the latched causes ANDed with the mask. A cause latches even while its mask bit is 0, so setting the mask later exposes it.
- R7: Writing 1 to a bit at cause-window offset 0x18 clears that pin's cause, and this offset reads as zero. If an edge and a clear hit the same bit in the same cycle, the cause stays set.
- R8: `irq` is high exactly when some cause bit and its mask bit are both 1.
- R9: Bits at or above `NPINS` read as zero in every register and ignore writes. The matching `outEn`/`outData` bits stay 0, and the matching `pinIn` bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe, one write per cycle it is high |
| winSel | input | 2 | Window: 0 main, 1 cause, 2 set, 3 clear |
| addr | input | 5 | Byte offset inside the window |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `winSel`/`addr` |
| pinIn | input | 32 | Asynchronous pin input levels |
| outEn | output | 32 | Per-pin output enable |
| outData | output | 32 | Per-pin output data |
| irq | output | 1 | Level interrupt, any unmasked cause pending |

## Verification
The checker watches these on every cycle:
- Set-window and clear-window writes land on exactly the written bits of the output registers.
- Outputs do not move when no write occurs.
- Bits above the pin count never rise.
- A zeroed event mask silences the interrupt.

Other behaviour depends on stimulus history, so only the bench's scenarios can show it:
- Edge qualification under each enable combination.
- Causes that latch while masked.
- An edge winning over a clear that lands in the same cycle.
- Synchronizer latency seen on the level register.

// File: rtl/gpio_edge_pkg.sv
`timescale 1ns/1ps
package gpio_edge_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 5;

  typedef enum logic [1:0] {
    WIN_MAIN  = 2'd0,
    WIN_CAUSE = 2'd1,
    WIN_SET   = 2'd2,
    WIN_CLR   = 2'd3
  } winT;

  typedef enum logic [2:0] {
    RD_ZERO, RD_RISE, RD_FALL, RD_LEVEL, RD_CAUSE, RD_MASK, RD_OE, RD_DATA
  } rdSelT;

  typedef struct packed {
    logic  oeSet;
    logic  oeClr;
    logic  doSet;
    logic  doClr;
    logic  riseWr;
    logic  fallWr;
    logic  maskWr;
    logic  causeClr;
    rdSelT rdSel;
  } strobeT;
endpackage

// File: rtl/gpio_edge_ctrl_dec.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_dec
  import gpio_edge_pkg::*;
(
  input  logic              wrEn,
  input  logic [1:0]        winSel,
  input  logic [ADDR_W-1:0] addr,
  output strobeT            strobe
);
  winT win;
  assign win = winT'(winSel);

  always_comb begin
    strobe = '0;
    strobe.rdSel = RD_ZERO;
    unique case (win)
      WIN_MAIN: begin
        if (addr == 5'h00) begin strobe.rdSel = RD_RISE; strobe.riseWr = wrEn; end
        if (addr == 5'h04) begin strobe.rdSel = RD_FALL; strobe.fallWr = wrEn; end
        if (addr == 5'h08) strobe.rdSel = RD_LEVEL;
      end
      WIN_CAUSE: begin
        if (addr == 5'h00) strobe.rdSel = RD_CAUSE;
        if (addr == 5'h14) begin strobe.rdSel = RD_MASK; strobe.maskWr = wrEn; end
        if (addr == 5'h18) strobe.causeClr = wrEn;
      end
      WIN_SET: begin
        if (addr == 5'h00) begin strobe.rdSel = RD_OE;   strobe.oeSet = wrEn; end
        if (addr == 5'h04) begin strobe.rdSel = RD_DATA; strobe.doSet = wrEn; end
      end
      WIN_CLR: begin
        if (addr == 5'h00) begin strobe.rdSel = RD_OE;   strobe.oeClr = wrEn; end
        if (addr == 5'h04) begin strobe.rdSel = RD_DATA; strobe.doClr = wrEn; end
      end
      default: strobe.rdSel = RD_ZERO;
    endcase
  end
endmodule

// File: rtl/gpio_edge_datapath.sv
`timescale 1ns/1ps
module gpio_edge_datapath
  import gpio_edge_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [WORD_W-1:0] wrData,
  input  logic [WORD_W-1:0] pinIn,
  output logic [WORD_W-1:0] rdData,
  output logic [WORD_W-1:0] outEn,
  output logic [WORD_W-1:0] outData,
  output logic              irq
);
  localparam logic [WORD_W-1:0] PIN_MASK = {WORD_W{1'b1}} >> (WORD_W - NPINS);

  logic [WORD_W-1:0] wrBits;
  logic [WORD_W-1:0] sync1, sync2, prevLvl;
  logic [WORD_W-1:0] riseEn, fallEn, causeReg, evMask;
  logic [WORD_W-1:0] edgeHit, shownCause;

  assign wrBits = wrData & PIN_MASK;

  // two-flop synchronizer followed by a history flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1   <= '0;
      sync2   <= '0;
      prevLvl <= '0;
    end else begin
      sync1   <= pinIn & PIN_MASK;
      sync2   <= sync1;
      prevLvl <= sync2;
    end
  end

  assign edgeHit = ((sync2 & ~prevLvl & riseEn) | (~sync2 & prevLvl & fallEn)) & PIN_MASK;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outEn    <= '0;
      outData  <= '0;
      riseEn   <= '0;
      fallEn   <= '0;
      evMask   <= '0;
      causeReg <= '0;
    end else begin
      if (strobe.oeSet)  outEn   <= outEn | wrBits;
      if (strobe.oeClr)  outEn   <= outEn & ~wrBits;
      if (strobe.doSet)  outData <= outData | wrBits;
      if (strobe.doClr)  outData <= outData & ~wrBits;
      if (strobe.riseWr) riseEn  <= wrBits;
      if (strobe.fallWr) fallEn  <= wrBits;
      if (strobe.maskWr) evMask  <= wrBits;
      // a fresh edge takes precedence over a same-cycle clear
      causeReg <= (causeReg & ~(strobe.causeClr ? wrBits : '0)) | edgeHit;
    end
  end

  assign shownCause = causeReg & evMask;
  assign irq = |shownCause;

  always_comb begin
    unique case (strobe.rdSel)
      RD_RISE:  rdData = riseEn;
      RD_FALL:  rdData = fallEn;
      RD_LEVEL: rdData = sync2;
      RD_CAUSE: rdData = shownCause;
      RD_MASK:  rdData = evMask;
      RD_OE:    rdData = outEn;
      RD_DATA:  rdData = outData;
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio_edge_ctrl.sv
`timescale 1ns/1ps
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  winSel,
  input  logic [4:0]  addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic [31:0] pinIn,
  output logic [31:0] outEn,
  output logic [31:0] outData,
  output logic        irq
);
  strobeT strobe;

  gpio_edge_ctrl_dec dec_i (
    .wrEn(wrEn), .winSel(winSel), .addr(addr), .strobe(strobe)
  );

  gpio_edge_datapath #(.NPINS(NPINS)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .pinIn(pinIn),
    .rdData(rdData), .outEn(outEn), .outData(outData), .irq(irq)
  );
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_chk #(
  parameter int NPINS = 32
) (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [1:0]  winSel,
  input logic [4:0]  addr,
  input logic [31:0] wrData,
  input logic [31:0] outEn,
  input logic [31:0] outData,
  input logic        irq
);
  localparam logic [31:0] PMASK = 32'hFFFF_FFFF >> (32 - NPINS);

  // R2: set-window write raises every written output-enable bit
  p_oe_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && winSel == 2'd2 && addr == 5'h00)
      |=> ((outEn & $past(wrData) & PMASK) == ($past(wrData) & PMASK)));

  // R3: clear-window write drops every written output-data bit
  p_do_clr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && winSel == 2'd3 && addr == 5'h04) |=> ((outData & $past(wrData)) == 32'h0));

  // R2: no write, no change on the output registers
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(outEn) && $stable(outData)));

  // R9: unimplemented pins never drive
  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((outEn | outData) & ~PMASK) == 32'h0);

  // R8: an all-zero mask silences the interrupt
  p_mask_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && winSel == 2'd1 && addr == 5'h14 && wrData == 32'h0) |=> !irq);
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.NPINS(NPINS)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .winSel(winSel), .addr(addr),
  .wrData(wrData), .outEn(outEn), .outData(outData), .irq(irq)
);

// File: tb/gpio_edge_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_tb_top;
  localparam int NP = 24;
  localparam logic [31:0] PM = 32'hFFFF_FFFF >> (32 - NP);

  logic clk = 0, rstN = 0, wrEn = 0;
  logic [1:0] winSel = 0;
  logic [4:0] addr = 0;
  logic [31:0] wrData = 0, pinIn = 0, rdData, outEn, outData;
  logic irq;

  int total = 0, bad = 0;
  logic [31:0] mOe = 0, mDo = 0, mRise = 0, mFall = 0, mCause = 0, mMask = 0, mPin = 0;

  always #2 clk = ~clk;

  gpio_edge_ctrl #(.NPINS(NP)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .winSel(winSel), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pinIn(pinIn), .outEn(outEn),
    .outData(outData), .irq(irq)
  );

  function automatic logic [31:0] edgesOf(logic [31:0] oldP, logic [31:0] newP);
    logic [31:0] o = oldP & PM, n = newP & PM;
    return ((~o & n) & mRise) | ((o & ~n) & mFall);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] w, logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1; winSel = w; addr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic rd(logic [1:0] w, logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    winSel = w; addr = a;
    #0.5 d = rdData;
  endtask

  task automatic setPins(logic [31:0] v);
    @(negedge clk);
    mCause |= edgesOf(mPin, v);
    mPin = v;
    pinIn = v;
    repeat (4) @(posedge clk);
  endtask

  task automatic checkAll(string req);
    logic [31:0] d;
    rd(2'd2, 5'h00, d); chk(req, d, mOe);
    rd(2'd3, 5'h04, d); chk(req, d, mDo);
    chk(req, outEn, mOe);
    chk(req, outData, mDo);
    rd(2'd1, 5'h00, d); chk(req, d, mCause & mMask);
    chk(req, {31'b0, irq}, {31'b0, |(mCause & mMask)});
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;

    // R1 reset state
    rd(2'd0, 5'h00, d); chk("R1", d, 0);
    rd(2'd0, 5'h04, d); chk("R1", d, 0);
    rd(2'd1, 5'h14, d); chk("R1", d, 0);
    checkAll("R1");

    // R2 / R3 / R9 directed
    wr(2'd2, 5'h00, 32'hFFFF_00F0); mOe = 32'hFFFF_00F0 & PM; checkAll("R2");
    wr(2'd2, 5'h04, 32'h0000_0003); mDo = 32'h3; checkAll("R2");
    wr(2'd3, 5'h00, 32'h0000_0030); mOe &= ~32'h30; checkAll("R3");
    chk("R9", outEn & ~PM, 0);

    // R4 synchronizer latency on level register
    @(negedge clk); pinIn = 32'hFF00_0005; mPin = pinIn;
    @(posedge clk); #0.5 winSel = 0; addr = 5'h08;
    #0.5 chk("R4", rdData, 0);
    @(posedge clk); #0.5 chk("R4", rdData, 32'hFF00_0005 & PM);
    repeat (3) @(posedge clk);

    // R5 edges without enables do nothing
    setPins(32'h0);
    checkAll("R5");
    wr(2'd0, 5'h00, 32'h1); mRise = 1;
    wr(2'd0, 5'h04, 32'h6 | 32'hFF00_0000); mFall = 32'h6;
    rd(2'd0, 5'h04, d); chk("R4", d, 32'h6);
    wr(2'd0, 5'h00, 32'h5); mRise = 32'h5;
    // R6 causes latch while masked
    setPins(32'h7);
    checkAll("R6");
    wr(2'd1, 5'h14, 32'hFFFF_FFFF); mMask = PM;
    checkAll("R6");
    chk("R5", {31'b0, irq}, 1);
    // R7 clear and zero read
    rd(2'd1, 5'h18, d); chk("R7", d, 0);
    wr(2'd1, 5'h18, 32'h5); mCause &= ~32'h5; checkAll("R7");
    // R8 mask off silences irq
    wr(2'd1, 5'h14, 32'h0); mMask = 0; checkAll("R8");
    wr(2'd1, 5'h14, PM); mMask = PM;

    // R7 edge wins over same-cycle clear (pin 2 both edges, falling now)
    wr(2'd1, 5'h18, 32'hFFFF_FFFF); mCause = 0;
    @(negedge clk); pinIn = 32'h3; mPin = 32'h3;
    @(posedge clk); @(posedge clk);
    @(negedge clk); wrEn = 1; winSel = 1; addr = 5'h18; wrData = 32'h4;
    @(posedge clk);
    @(negedge clk); wrEn = 0; mCause = 32'h4;
    checkAll("R7");

    // R9 upper pins ignored
    setPins(mPin | 32'hFF00_0000);
    wr(2'd0, 5'h00, 32'hFF00_0000); mRise = 0;
    rd(2'd0, 5'h00, d); chk("R9", d, 0);
    checkAll("R9");

    // random mix
    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 6);
      logic [31:0] v = $urandom;
      case (op)
        0: begin wr(2'd2, 5'h00, v); mOe |= v & PM; end
        1: begin wr(2'd3, 5'h00, v); mOe &= ~v; end
        2: begin wr(2'd2, 5'h04, v); mDo |= v & PM; end
        3: begin wr(2'd3, 5'h04, v); mDo &= ~v; end
        4: begin wr(2'd0, {$urandom_range(0, 1) == 0 ? 5'h00 : 5'h04}, v);
                 if (addr == 5'h00) mRise = v & PM; else mFall = v & PM; end
        5: begin wr(2'd1, {$urandom_range(0, 1) == 0 ? 5'h14 : 5'h18}, v);
                 if (addr == 5'h14) mMask = v & PM; else mCause &= ~v; end
        default: setPins(v);
      endcase
      checkAll("R2 R3 R5 R6 R7 R8 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule